// File: doc/BRIEF.md
# Serial Boot Loader Engine

The engine replaces a tiny boot program with hardware. It is a bus master on a simple synchronous memory bus. After reset it writes two setup values into a memory-mapped ACIA-style UART. It then moves received bytes into a fixed RAM window, one at a time. For each byte it polls the UART status register until the receive-ready flag is set. It then reads the data register and writes the byte to RAM.

The RAM address is the window base plus an 8-bit index. The index starts at 5 and the load ends when the index wraps to zero, so no byte count is stored anywhere. When the load ends, the engine raises a done flag and presents the address where the loaded code starts. The UART, the RAM and the processor that runs the loaded code are all outside the block.

Every bus access is a single transfer. The engine holds its strobe, address and write data until it samples `bus_ready` high on a rising clock edge. Only one access is outstanding at a time.

Top module: `sboot_engine`

## Requirements
- R1: While `rst` is high and after it, `bus_wr`, `bus_rd` and `boot_done` are 0. The first access after reset is a write of 0x05 to the UART command register at 0xFA02.
- R2: The second access is a write of 0x1E to the UART control register at 0xFA03, and it happens only after the command write has completed.
- R3: After setup, and after every stored byte, the engine reads the status register at 0xFA01. It repeats this read while bit 3 of the returned value is 0, whatever the other bits hold.
- R4: A status read that returns bit 3 = 1 is followed by exactly one read of the data register at 0xFA00.
- R5: The byte returned by a data read is written to address 0xC000 + index, where the index starts at 5. The engine writes nowhere except 0xC005..0xC0FF and the two UART setup registers.
- R6: The index increments after each stored byte. The load ends after the write to 0xC0FF, so exactly 251 bytes are stored. After that, no strobe is ever asserted again.
- R7: `boot_done` rises in the cycle after the last RAM write completes and stays high until reset. `boot_start` is 0xC005 while `boot_done` is high and 0 otherwise.
- R8: `bus_wr` and `bus_rd` are never high together. While a strobe is high and `bus_ready` is low, the strobes, `bus_addr` and `bus_wdata` keep their values in the next cycle. Read data is taken only on an edge where `bus_ready` is high.
- R9: A reset in the middle of a load restarts the whole sequence from the command write. The next byte is stored at 0xC005 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 16 | Address of the current transfer |
| bus_wdata | output | 8 | Write data of the current write transfer |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_rdata | input | 8 | Read data, valid when ready is high |
| bus_ready | input | 1 | Completes the current transfer at the rising edge |
| boot_done | output | 1 | Load complete, sticky until reset |
| boot_start | output | 16 | Start address of the loaded code while done is high, else 0 |

## Verification
A transfer completes on the rising edge where `bus_ready` is high. The strobes, address and data of the next transfer appear in the following cycle. `boot_done` rises one edge after the last write completes.

The bench drives `bus_ready` and `bus_rdata`, and samples every output, on the falling edge. At that point it first compares the outputs with its behavioural model. That model holds the state reached by the transfers that completed on the previous rising edge. Only then does the bench decide whether the current transfer completes, and move the model forward to the state that transfer will produce.

Waits on ready and repeated status polls shift all timing. The comparison therefore follows completed transfers and not a fixed cycle count.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // UART register offsets; the engine relies on this decode
    localparam logic [1:0] OFF_DATA = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd1;
    localparam logic [1:0] OFF_CMD  = 2'd2;
    localparam logic [1:0] OFF_CTRL = 2'd3;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_CTRL  = 3'd1,
        PH_POLL  = 3'd2,
        PH_FETCH = 3'd3,
        PH_STORE = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        byte_t data;
    } bus_req_t;

    function automatic addr_t uart_reg(input addr_t base, input logic [1:0] off);
        return base + addr_t'(off);
    endfunction

    function automatic addr_t window_addr(input addr_t base, input idx_t idx);
        return base + addr_t'(idx);
    endfunction

endpackage

// File: rtl/sboot_index.sv
module sboot_index
    import sboot_pkg::*;
#(
    parameter idx_t START = idx_t'(5)
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output idx_t idx,
    output logic last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= START;
        end else if (adv) begin
            idx <= idx + idx_t'(1);
        end
    end

    // the next increment wraps to zero
    assign last = &idx;

endmodule

// File: rtl/sboot_seq.sv
module sboot_seq
    import sboot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   xfer_done,
    input  logic   rx_flag,
    input  logic   is_last,
    output phase_e phase,
    output logic   capture,
    output logic   adv
);

    phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_CMD:   if (xfer_done) nxt = PH_CTRL;
            PH_CTRL:  if (xfer_done) nxt = PH_POLL;
            PH_POLL:  if (xfer_done && rx_flag) nxt = PH_FETCH;
            PH_FETCH: if (xfer_done) nxt = PH_STORE;
            PH_STORE: if (xfer_done) nxt = is_last ? PH_DONE : PH_POLL;
            PH_DONE:  nxt = PH_DONE;
            default:  nxt = PH_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CMD;
        end else begin
            phase <= nxt;
        end
    end

    assign capture = (phase == PH_FETCH) && xfer_done;
    assign adv     = (phase == PH_STORE) && xfer_done;

endmodule

// File: rtl/sboot_req.sv
module sboot_req
    import sboot_pkg::*;
#(
    parameter addr_t UART_BASE = 16'hFA00,
    parameter addr_t RAM_BASE  = 16'hC000,
    parameter byte_t CMD_VAL   = 8'h05,
    parameter byte_t CTRL_VAL  = 8'h1E
) (
    input  logic     rst,
    input  phase_e   phase,
    input  idx_t     idx,
    input  byte_t    rx_byte,
    output bus_req_t req
);

    always_comb begin
        req = '0;
        if (!rst) begin
            unique case (phase)
                PH_CMD: begin
                    req.wr   = 1'b1;
                    req.addr = uart_reg(UART_BASE, OFF_CMD);
                    req.data = CMD_VAL;
                end
                PH_CTRL: begin
                    req.wr   = 1'b1;
                    req.addr = uart_reg(UART_BASE, OFF_CTRL);
                    req.data = CTRL_VAL;
                end
                PH_POLL: begin
                    req.rd   = 1'b1;
                    req.addr = uart_reg(UART_BASE, OFF_STAT);
                end
                PH_FETCH: begin
                    req.rd   = 1'b1;
                    req.addr = uart_reg(UART_BASE, OFF_DATA);
                end
                PH_STORE: begin
                    req.wr   = 1'b1;
                    req.addr = window_addr(RAM_BASE, idx);
                    req.data = rx_byte;
                end
                default: req = '0;
            endcase
        end
    end

endmodule

// File: rtl/sboot_engine.sv
module sboot_engine
    import sboot_pkg::*;
#(
    parameter addr_t UART_BASE   = 16'hFA00,
    parameter addr_t RAM_BASE    = 16'hC000,
    parameter idx_t  IDX_START   = 8'h05,
    parameter byte_t CMD_VAL     = 8'h05,
    parameter byte_t CTRL_VAL    = 8'h1E,
    parameter int    RX_FLAG_BIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_wr,
    output logic        bus_rd,
    input  logic [7:0]  bus_rdata,
    input  logic        bus_ready,
    output logic        boot_done,
    output logic [15:0] boot_start
);

    localparam addr_t START_ADDR = window_addr(RAM_BASE, IDX_START);

    phase_e   phase;
    idx_t     idx;
    logic     is_last;
    logic     capture;
    logic     adv;
    logic     xfer_done;
    byte_t    rx_byte;
    bus_req_t req;

    assign xfer_done = (req.wr || req.rd) && bus_ready;

    sboot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .xfer_done (xfer_done),
        .rx_flag   (bus_rdata[RX_FLAG_BIT]),
        .is_last   (is_last),
        .phase     (phase),
        .capture   (capture),
        .adv       (adv)
    );

    sboot_index #(.START(IDX_START)) u_idx (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .idx  (idx),
        .last (is_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
        end else if (capture) begin
            rx_byte <= bus_rdata;
        end
    end

    sboot_req #(
        .UART_BASE (UART_BASE),
        .RAM_BASE  (RAM_BASE),
        .CMD_VAL   (CMD_VAL),
        .CTRL_VAL  (CTRL_VAL)
    ) u_req (
        .rst     (rst),
        .phase   (phase),
        .idx     (idx),
        .rx_byte (rx_byte),
        .req     (req)
    );

    assign bus_addr   = req.addr;
    assign bus_wdata  = req.data;
    assign bus_wr     = req.wr;
    assign bus_rd     = req.rd;
    assign boot_done  = (phase == PH_DONE);
    assign boot_start = boot_done ? START_ADDR : '0;

endmodule

// File: rtl/sboot_chk.sv
module sboot_chk #(
    parameter logic [15:0] UART_BASE = 16'hFA00,
    parameter logic [15:0] RAM_BASE  = 16'hC000,
    parameter logic [7:0]  IDX_START = 8'h05,
    parameter logic [7:0]  CMD_VAL   = 8'h05
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_ready,
    input logic        boot_done,
    input logic [15:0] boot_start
);

    localparam logic [15:0] WIN_LO = RAM_BASE + {8'h00, IDX_START};
    localparam logic [15:0] WIN_HI = RAM_BASE + 16'h00FF;

    AST_FIRST_CMD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_wr && bus_addr == UART_BASE + 16'd2 && bus_wdata == CMD_VAL)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd)); // R8

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !bus_ready) |=>
        ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd))); // R8

    AST_RD_TARGET: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_addr == UART_BASE || bus_addr == UART_BASE + 16'd1)); // R3

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> ((bus_addr >= WIN_LO && bus_addr <= WIN_HI) ||
                    bus_addr == UART_BASE + 16'd2 || bus_addr == UART_BASE + 16'd3)); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (!bus_wr && !bus_rd)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done); // R7

    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        boot_start == (boot_done ? WIN_LO : 16'h0000)); // R7

endmodule

bind sboot_engine sboot_chk #(
    .UART_BASE (UART_BASE),
    .RAM_BASE  (RAM_BASE),
    .IDX_START (IDX_START),
    .CMD_VAL   (CMD_VAL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_ready  (bus_ready),
    .boot_done  (boot_done),
    .boot_start (boot_start)
);

// File: tb/tb_sboot_engine.sv
module tb_sboot_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam int NBYTES     = 251;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_ready = 1'b0;
    logic        boot_done;
    logic [15:0] boot_start;

    sboot_engine dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .bus_ready  (bus_ready),
        .boot_done  (boot_done),
        .boot_start (boot_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural model state
    int exp_phase = 0;      // 0 cmd,1 ctrl,2 poll,3 data read,4 store,5 done
    int exp_idx = 5;
    int exp_byte = 0;
    int rx_ptr = 0;
    int wait_left = 2;
    int stored_cnt = 0;
    int stray_wr = 0;
    int seed = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  ram [256];

    bit          pend = 0;
    logic [15:0] prev_addr;
    logic [7:0]  prev_wdata;
    logic        prev_wr, prev_rd;

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((k * 37 + s * 91 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // responder, UART/RAM model and per-cycle reference comparison
    always @(negedge clk) begin
        logic        e_wr, e_rd, rdy, inwin, uartw;
        logic [15:0] e_addr;
        logic [7:0]  e_data;
        cyc++;
        if (cyc > WD_LIMIT) begin
            chk(1'b0, "watchdog", 32'(cyc), 32'(WD_LIMIT));
            summary();
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst) begin
            // R1 R9: quiet outputs in reset
            chk(!bus_wr && !bus_rd, "R1/R9 strobes in reset", {30'd0, bus_wr, bus_rd}, 32'd0);
            chk(!boot_done && boot_start == 16'h0, "R1/R9 done in reset", {15'd0, boot_done, boot_start}, 32'd0);
            exp_phase = 0; exp_idx = 5; rx_ptr = 0; wait_left = 2;
            stored_cnt = 0; stray_wr = 0; pend = 0;
            bus_ready = 1'b0; bus_rdata = 8'h00;
            for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        end else begin
            // R7 done and start address
            chk(boot_done == (exp_phase == 5), "R7 done", 32'(boot_done), 32'(exp_phase == 5));
            chk(boot_start == ((exp_phase == 5) ? 16'hC005 : 16'h0000), "R7 start",
                32'(boot_start), (exp_phase == 5) ? 32'hC005 : 32'h0);
            // R8 hold and single strobe
            chk(!(bus_wr && bus_rd), "R8 both strobes", {30'd0, bus_wr, bus_rd}, 32'd0);
            if (pend)
                chk(bus_addr == prev_addr && bus_wdata == prev_wdata && bus_wr == prev_wr && bus_rd == prev_rd,
                    "R8 held request", {bus_wr, bus_rd, 6'd0, bus_wdata, bus_addr},
                    {prev_wr, prev_rd, 6'd0, prev_wdata, prev_addr});
            // expected request from the model
            e_wr = 0; e_rd = 0; e_addr = 16'h0; e_data = 8'h0;
            case (exp_phase)
                0: begin e_wr = 1; e_addr = 16'hFA02; e_data = 8'h05; end
                1: begin e_wr = 1; e_addr = 16'hFA03; e_data = 8'h1E; end
                2: begin e_rd = 1; e_addr = 16'hFA01; end
                3: begin e_rd = 1; e_addr = 16'hFA00; end
                4: begin e_wr = 1; e_addr = 16'hC000 + 16'(exp_idx); e_data = 8'(exp_byte); end
                default: ;
            endcase
            chk(bus_wr == e_wr && bus_rd == e_rd && (!(e_wr || e_rd) || bus_addr == e_addr) &&
                (!e_wr || bus_wdata == e_data),
                (exp_phase == 0) ? "R1/R9 command write" :
                (exp_phase == 1) ? "R2 control write" :
                (exp_phase == 2) ? "R3 status poll" :
                (exp_phase == 3) ? "R4 data read" :
                (exp_phase == 4) ? "R5 RAM store" : "R6 quiet after load",
                {bus_wr, bus_rd, 6'd0, bus_wdata, bus_addr}, {e_wr, e_rd, 6'd0, e_data, e_addr});
            inwin = bus_addr >= 16'hC005 && bus_addr <= 16'hC0FF;
            uartw = bus_addr == 16'hFA02 || bus_addr == 16'hFA03;
            if (bus_wr && !inwin && !uartw) stray_wr++;
            // decide completion of the current transfer at the next rising edge
            rdy = lfsr[0] | lfsr[3];
            bus_ready = rdy;
            bus_rdata = 8'h08; // misleading value when not ready
            if ((bus_wr || bus_rd) && rdy) begin
                case (exp_phase)
                    0: exp_phase = 1;
                    1: exp_phase = 2;
                    2: begin
                        if (wait_left == 0) begin
                            bus_rdata = 8'h08 | (8'(rx_ptr * 5) & 8'hF7);
                            exp_phase = 3;
                        end else begin
                            bus_rdata = 8'hF7; // every bit but the flag
                            wait_left--;
                        end
                    end
                    3: begin
                        bus_rdata = pat(seed, rx_ptr);
                        exp_byte = int'(pat(seed, rx_ptr));
                        rx_ptr++;
                        wait_left = (rx_ptr * 3) % 4;
                        exp_phase = 4;
                    end
                    4: begin
                        if (bus_wr) ram[bus_addr[7:0]] = bus_wdata;
                        stored_cnt++;
                        exp_idx = (exp_idx + 1) & 255;
                        exp_phase = (exp_idx == 0) ? 5 : 2;
                    end
                    default: ;
                endcase
            end
            pend = (bus_wr || bus_rd) && !rdy;
            prev_addr = bus_addr; prev_wdata = bus_wdata;
            prev_wr = bus_wr; prev_rd = bus_rd;
        end
    end

    task automatic check_load(input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < NBYTES; k++)
            if (ram[k + 5] !== pat(seed, k)) bad++;
        chk(bad == 0, {tag, " R5 RAM contents"}, 32'(bad), 32'd0);
        chk(ram[0] == 8'h00 && ram[4] == 8'h00, {tag, " R5 below window untouched"},
            {16'd0, ram[0], ram[4]}, 32'd0);
        chk(stored_cnt == NBYTES, {tag, " R6 byte count"}, 32'(stored_cnt), 32'(NBYTES));
        chk(stray_wr == 0, {tag, " R5 stray writes"}, 32'(stray_wr), 32'd0);
    endtask

    task automatic pulse_reset(input int n);
        @(negedge clk); #1 rst = 1'b1;
        repeat (n) @(negedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        seed = 0;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        // full load with wait states and slow receive flag
        wait (exp_phase == 5);
        repeat (20) @(negedge clk);
        check_load("run1");
        chk(boot_done && boot_start == 16'hC005, "R7 done holds", {15'd0, boot_done, boot_start}, 32'h1C005);
        // reset from the done state, then reset in the middle of a load
        seed = 1;
        pulse_reset(3);
        wait (stored_cnt == 40);
        seed = 2;
        pulse_reset(2);
        // R9: restart must store the new stream from 0xC005 onward
        wait (exp_phase == 5);
        repeat (10) @(negedge clk);
        check_load("run2 R9");
        summary();
    end

endmodule